// File: doc/BRIEF.md
# Transducer command decoder

This block is the command front end of a smart-sensor channel. It takes octets from a UART receiver and assembles them into framed commands. It acts on four commands: operate, idle, read descriptor and write descriptor. For each frame it sends one reply as octets to a UART transmitter, which accepts them with a valid/ready handshake. Operate and idle set a one-bit channel mode. The read and write commands use a byte-wide synchronous port to an external descriptor store (the TEDS memory).

A command frame has a fixed header and then a payload. All multi-octet fields are sent most significant octet first. The header is six octets: channel identifier (2 octets), class (1), function (1) and payload length (2). A read or write payload starts with a descriptor identifier and a 4-octet offset. A write payload then carries its data octets and ends with one check octet. Write data is held in a small staging buffer and goes to the store only after the whole frame has been validated, so a rejected write leaves the store untouched.

Every reply starts with a flag octet (0x01 for success, 0x00 for failure), then a 2-octet length, then a response code. A successful read adds the fetched octets after the code. A frame that stops partway for too long is dropped and answered with a code of its own.

Top module: `tcmd_decoder`

## Requirements
- R1: The header is decoded as channel[15:0], class, function, length[15:0], most significant octet first. A valid operate (class 0x04, function 0x01, length 0) or idle (class 0x04, function 0x02, length 0) is answered 0x01, 0x00, 0x01, 0xC7.
- R2: `chan_op` is 0 after reset. A successful operate sets it to 1 and a successful idle clears it to 0. No rejected frame changes it.
- R3: A channel field other than CHAN_ID (default 1) is answered 0x00, 0x00, 0x01, 0xC1, whatever the class, function and length.
- R4: With a valid channel, a class/function pair other than (0x04,0x01), (0x04,0x02), (0x01,0x02) and (0x01,0x03) is answered with code 0xC2.
- R5: With a known pair, a wrong length is answered with code 0xC0. The accepted lengths are 0 for operate and idle, 5 for read, and 7 to 6+WBUF_N for write. Exactly `length` payload octets are consumed before the reply.
- R6: A read payload is the descriptor ID followed by offset[31:0]. A valid read is answered 0x01, then length 1+READ_N as two octets, then 0xC8, then READ_N store octets in ascending address order starting at the offset.
- R7: A write payload is the descriptor ID, offset[31:0], n data octets and a check octet equal to the bitwise inverse of the 8-bit sum of the data octets. A valid write stores the n octets at offset..offset+n-1 in consecutive cycles and is then answered with code 0xC7.
- R8: A descriptor ID other than TEDS_ID (default 0x03) in a read or write is answered with code 0xC4. This code takes precedence over 0xC5 and 0xC6.
- R9: A read or write with offset + count > DEPTH, compared on the full 32-bit offset, is answered with code 0xC5. This code takes precedence over 0xC6.
- R10: A write whose check octet does not match is answered with code 0xC6. No rejected command writes the store.
- R11: If a frame has started and no octet arrives for TIMEOUT clocks, the frame is dropped and answered with code 0xC3. The next octet then starts a new header.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values. Reply octets come out in order whatever pattern `tx_ready` follows.
- R13: Octets that arrive after a frame completes and before its reply has been fully accepted are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received octet strobe, one cycle per octet |
| rx_data | input | 8 | Received octet |
| tx_ready | input | 1 | Transmitter can take an octet |
| tx_valid | output | 1 | Reply octet available |
| tx_data | output | 8 | Reply octet |
| chan_op | output | 1 | Channel mode: 1 operational, 0 inactive |
| teds_we | output | 1 | Store write enable |
| teds_addr | output | $clog2(DEPTH) | Store address |
| teds_wdata | output | 8 | Store write data |
| teds_rdata | input | 8 | Store read data, one cycle after the address |

## Verification
The assertions check three properties on every cycle. The transmit octet must stay stable while it is stalled. Store writes must go to consecutive addresses and must never overlap a reply. The mode bit may change only in the cycle after a command completes. The reply contents depend on whole frames, so only the bench scenarios can show them. These scenarios cover the error-code precedence, exact payload consumption for odd lengths, checksum rejection leaving the store intact, timeout recovery and discarding of octets during a stalled reply. The bench sweeps class/function pairs, channel values, every read offset across the store boundary and every write size at both ends of the store.

// File: rtl/tcmd_pkg.sv
package tcmd_pkg;
  localparam logic [7:0] RC_HDR   = 8'hC0;
  localparam logic [7:0] RC_CHAN  = 8'hC1;
  localparam logic [7:0] RC_CLSFN = 8'hC2;
  localparam logic [7:0] RC_LOST  = 8'hC3;
  localparam logic [7:0] RC_TID   = 8'hC4;
  localparam logic [7:0] RC_POS   = 8'hC5;
  localparam logic [7:0] RC_SUM   = 8'hC6;
  localparam logic [7:0] RC_OK    = 8'hC7;
  localparam logic [7:0] RC_RD    = 8'hC8;

  typedef enum logic [1:0] {K_OPER, K_IDLE, K_READ, K_WRITE} cmd_kind_e;
endpackage

// File: rtl/tcmd_frame_parser.sv
module tcmd_frame_parser
  import tcmd_pkg::*;
#(
  parameter int CHAN_ID = 1,
  parameter int TEDS_ID = 3,
  parameter int DEPTH   = 128,
  parameter int READ_N  = 4,
  parameter int WBUF_N  = 8,
  parameter int TIMEOUT = 1000,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = (WBUF_N > 1) ? $clog2(WBUF_N) : 1,
  localparam int CW = $clog2(WBUF_N + 1),
  localparam int TW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          release_i,
  output logic          done_o,
  output logic [7:0]    v_code,
  output cmd_kind_e     v_kind,
  output logic [AW-1:0] v_base,
  output logic [CW-1:0] v_count,
  output logic          buf_we,
  output logic [IW-1:0] buf_idx,
  output logic [7:0]    buf_byte
);
  localparam logic [15:0] CH_W   = 16'(CHAN_ID);
  localparam logic [7:0]  TID_W  = 8'(TEDS_ID);
  localparam logic [15:0] WR_MIN = 16'd7;
  localparam logic [15:0] WR_MAX = 16'(6 + WBUF_N);

  typedef enum logic [1:0] {PS_HDR, PS_PAY, PS_WAIT} pstate_e;
  pstate_e     state;
  logic [2:0]  hcnt;
  logic [15:0] ch_q;
  logic [7:0]  cls_q, fn_q, lenh_q, herr_q, tid_q, sum_q;
  cmd_kind_e   kind_q;
  logic [15:0] plen_q, pcnt_q;
  logic [31:0] off_q;
  logic [TW-1:0] tmo_q;

  // header decode on the sixth octet
  logic [15:0] len_w;
  cmd_kind_e   hkind;
  logic [7:0]  herr;
  always_comb begin
    len_w = {lenh_q, rx_data};
    hkind = K_OPER;
    herr  = 8'h00;
    if (ch_q != CH_W) herr = RC_CHAN;
    else if (cls_q == 8'h04 && fn_q == 8'h01) begin
      hkind = K_OPER;
      if (len_w != 16'd0) herr = RC_HDR;
    end else if (cls_q == 8'h04 && fn_q == 8'h02) begin
      hkind = K_IDLE;
      if (len_w != 16'd0) herr = RC_HDR;
    end else if (cls_q == 8'h01 && fn_q == 8'h02) begin
      hkind = K_READ;
      if (len_w != 16'd5) herr = RC_HDR;
    end else if (cls_q == 8'h01 && fn_q == 8'h03) begin
      hkind = K_WRITE;
      if (len_w < WR_MIN || len_w > WR_MAX) herr = RC_HDR;
    end else herr = RC_CLSFN;
  end

  // payload end decode
  logic        last_w, over_w, in_off;
  logic [31:0] off_w;
  logic [15:0] n_w;
  logic [7:0]  pcode;
  always_comb begin
    last_w = (pcnt_q == plen_q - 16'd1);
    in_off = (pcnt_q >= 16'd1) && (pcnt_q <= 16'd4);
    off_w  = in_off ? {off_q[23:0], rx_data} : off_q;
    n_w    = (kind_q == K_WRITE) ? (plen_q - 16'd6) : 16'(READ_N);
    over_w = ({1'b0, off_w} + 33'(n_w)) > 33'(DEPTH);
    if (herr_q != 8'h00)                         pcode = herr_q;
    else if (tid_q != TID_W)                     pcode = RC_TID;
    else if (over_w)                             pcode = RC_POS;
    else if (kind_q == K_WRITE && (~sum_q != rx_data)) pcode = RC_SUM;
    else if (kind_q == K_READ)                   pcode = RC_RD;
    else                                         pcode = RC_OK;
  end

  assign buf_we   = (state == PS_PAY) && rx_valid && (herr_q == 8'h00) &&
                    (kind_q == K_WRITE) && (pcnt_q >= 16'd5) && !last_w;
  assign buf_idx  = IW'(pcnt_q - 16'd5);
  assign buf_byte = rx_data;

  logic mid_frame;
  assign mid_frame = ((state == PS_HDR) && (hcnt != 3'd0)) || (state == PS_PAY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PS_HDR; hcnt <= '0; ch_q <= '0; cls_q <= '0; fn_q <= '0;
      lenh_q <= '0; herr_q <= '0; tid_q <= '0; sum_q <= '0; kind_q <= K_OPER;
      plen_q <= '0; pcnt_q <= '0; off_q <= '0; tmo_q <= '0;
      done_o <= 1'b0; v_code <= '0; v_kind <= K_OPER; v_base <= '0; v_count <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        PS_HDR: if (rx_valid) begin
          hcnt <= hcnt + 3'd1;
          case (hcnt)
            3'd0: ch_q[15:8] <= rx_data;
            3'd1: ch_q[7:0]  <= rx_data;
            3'd2: cls_q      <= rx_data;
            3'd3: fn_q       <= rx_data;
            3'd4: lenh_q     <= rx_data;
            default: begin
              hcnt   <= '0;
              herr_q <= herr;
              kind_q <= hkind;
              plen_q <= len_w;
              pcnt_q <= '0;
              sum_q  <= '0;
              off_q  <= '0;
              tid_q  <= '0;
              if (len_w == 16'd0) begin
                done_o  <= 1'b1;
                v_code  <= (herr != 8'h00) ? herr : RC_OK;
                v_kind  <= hkind;
                v_base  <= '0;
                v_count <= '0;
                state   <= PS_WAIT;
              end else state <= PS_PAY;
            end
          endcase
        end
        PS_PAY: if (rx_valid) begin
          pcnt_q <= pcnt_q + 16'd1;
          if (pcnt_q == 16'd0) tid_q <= rx_data;
          if (in_off) off_q <= off_w;
          if (pcnt_q >= 16'd5 && !last_w) sum_q <= sum_q + rx_data;
          if (last_w) begin
            done_o  <= 1'b1;
            v_code  <= pcode;
            v_kind  <= kind_q;
            v_base  <= off_w[AW-1:0];
            v_count <= CW'(n_w);
            state   <= PS_WAIT;
          end
        end
        default: if (release_i) state <= PS_HDR;
      endcase
      // silence watchdog inside a frame
      if (!mid_frame || rx_valid) tmo_q <= '0;
      else if (tmo_q == TW'(TIMEOUT - 1)) begin
        tmo_q   <= '0;
        hcnt    <= '0;
        done_o  <= 1'b1;
        v_code  <= RC_LOST;
        v_kind  <= kind_q;
        v_base  <= '0;
        v_count <= '0;
        state   <= PS_WAIT;
      end else tmo_q <= tmo_q + TW'(1);
    end
  end

  // R13
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == PS_WAIT && !release_i) |=> (state == PS_WAIT && !done_o));

  // R5
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (v_code[7:4] == 4'hC && v_code[3:0] <= 4'h8));
endmodule

// File: rtl/tcmd_wr_stage.sv
module tcmd_wr_stage #(
  parameter int DEPTH  = 128,
  parameter int WBUF_N = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = (WBUF_N > 1) ? $clog2(WBUF_N) : 1,
  localparam int CW = $clog2(WBUF_N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          buf_we,
  input  logic [IW-1:0] buf_idx,
  input  logic [7:0]    buf_byte,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] count,
  output logic          teds_we,
  output logic [AW-1:0] teds_addr,
  output logic [7:0]    teds_wdata,
  output logic          done_o
);
  logic [7:0]    wbuf [WBUF_N];
  logic          active;
  logic [IW-1:0] j;
  logic [CW-1:0] left;
  logic [AW-1:0] next_addr;

  always_ff @(posedge clk) begin
    if (buf_we) wbuf[buf_idx] <= buf_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0; j <= '0; left <= '0; next_addr <= '0;
      teds_we <= 1'b0; teds_addr <= '0; teds_wdata <= '0; done_o <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      teds_we <= 1'b0;
      if (start) begin
        active    <= 1'b1;
        j         <= '0;
        left      <= count;
        next_addr <= base;
      end else if (active) begin
        teds_we    <= 1'b1;
        teds_addr  <= next_addr;
        teds_wdata <= wbuf[j];
        next_addr  <= next_addr + AW'(1);
        j          <= j + IW'(1);
        left       <= left - CW'(1);
        if (left == CW'(1)) begin
          active <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  // R7
  consec_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (teds_we && $past(teds_we)) |-> (teds_addr == $past(teds_addr) + AW'(1)));
endmodule

// File: rtl/tcmd_reply_gen.sv
module tcmd_reply_gen #(
  parameter int DEPTH  = 128,
  parameter int READ_N = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          flag_ok,
  input  logic [7:0]    code,
  input  logic          with_data,
  input  logic [AW-1:0] base,
  input  logic          tx_ready,
  input  logic [7:0]    teds_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic          done_o
);
  localparam logic [15:0] LEN_RD = 16'(1 + READ_N);

  typedef enum logic [2:0] {RG_IDLE, RG_HDR, RG_FETCH, RG_LOAD, RG_SEND} rstate_e;
  rstate_e    state;
  logic [1:0] k;
  logic [7:0] j, code_q;
  logic       wd_q;

  assign busy = (state != RG_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RG_IDLE; k <= '0; j <= '0; code_q <= '0; wd_q <= 1'b0;
      tx_valid <= 1'b0; tx_data <= '0; rd_addr <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        RG_IDLE: if (start) begin
          code_q   <= code;
          wd_q     <= with_data;
          rd_addr  <= base;
          j        <= '0;
          k        <= '0;
          tx_data  <= flag_ok ? 8'h01 : 8'h00;
          tx_valid <= 1'b1;
          state    <= RG_HDR;
        end
        RG_HDR: if (tx_ready) begin
          k <= k + 2'd1;
          case (k)
            2'd0: tx_data <= wd_q ? LEN_RD[15:8] : 8'h00;
            2'd1: tx_data <= wd_q ? LEN_RD[7:0] : 8'h01;
            2'd2: tx_data <= code_q;
            default: begin
              tx_valid <= 1'b0;
              if (wd_q) state <= RG_FETCH;
              else begin
                state  <= RG_IDLE;
                done_o <= 1'b1;
              end
            end
          endcase
        end
        RG_FETCH: state <= RG_LOAD;
        RG_LOAD: begin
          tx_data  <= teds_rdata;
          tx_valid <= 1'b1;
          state    <= RG_SEND;
        end
        default: if (tx_ready) begin
          tx_valid <= 1'b0;
          rd_addr  <= rd_addr + AW'(1);
          j        <= j + 8'd1;
          if (j == 8'(READ_N - 1)) begin
            state  <= RG_IDLE;
            done_o <= 1'b1;
          end else state <= RG_FETCH;
        end
      endcase
    end
  end

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R12
  tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tx_valid);
endmodule

// File: rtl/tcmd_decoder.sv
module tcmd_decoder
  import tcmd_pkg::*;
#(
  parameter int CHAN_ID = 1,
  parameter int TEDS_ID = 3,
  parameter int DEPTH   = 128,
  parameter int READ_N  = 4,
  parameter int WBUF_N  = 8,
  parameter int TIMEOUT = 1000,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = (WBUF_N > 1) ? $clog2(WBUF_N) : 1,
  localparam int CW = $clog2(WBUF_N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          chan_op,
  output logic          teds_we,
  output logic [AW-1:0] teds_addr,
  output logic [7:0]    teds_wdata,
  input  logic [7:0]    teds_rdata
);
  logic          cmd_done, buf_we, wr_done, rep_done, rep_busy;
  logic [7:0]    v_code, buf_byte;
  cmd_kind_e     v_kind;
  logic [AW-1:0] v_base, wr_addr, rd_addr;
  logic [CW-1:0] v_count;
  logic [IW-1:0] buf_idx;
  logic          wr_start, rep_start;

  tcmd_frame_parser #(
    .CHAN_ID(CHAN_ID), .TEDS_ID(TEDS_ID), .DEPTH(DEPTH),
    .READ_N(READ_N), .WBUF_N(WBUF_N), .TIMEOUT(TIMEOUT)
  ) u_parse (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .release_i(rep_done), .done_o(cmd_done), .v_code(v_code), .v_kind(v_kind),
    .v_base(v_base), .v_count(v_count), .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_byte(buf_byte)
  );

  assign wr_start  = cmd_done && (v_code == RC_OK) && (v_kind == K_WRITE);
  assign rep_start = (cmd_done && !wr_start) || wr_done;

  tcmd_wr_stage #(.DEPTH(DEPTH), .WBUF_N(WBUF_N)) u_wr (
    .clk(clk), .rst(rst), .buf_we(buf_we), .buf_idx(buf_idx), .buf_byte(buf_byte),
    .start(wr_start), .base(v_base), .count(v_count), .teds_we(teds_we),
    .teds_addr(wr_addr), .teds_wdata(teds_wdata), .done_o(wr_done)
  );

  tcmd_reply_gen #(.DEPTH(DEPTH), .READ_N(READ_N)) u_reply (
    .clk(clk), .rst(rst), .start(rep_start), .flag_ok(v_code >= RC_OK),
    .code(v_code), .with_data(v_code == RC_RD), .base(v_base),
    .tx_ready(tx_ready), .teds_rdata(teds_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .rd_addr(rd_addr), .busy(rep_busy), .done_o(rep_done)
  );

  assign teds_addr = teds_we ? wr_addr : rd_addr;

  always_ff @(posedge clk) begin
    if (rst) chan_op <= 1'b0;
    else if (cmd_done && v_code == RC_OK) begin
      if (v_kind == K_OPER) chan_op <= 1'b1;
      else if (v_kind == K_IDLE) chan_op <= 1'b0;
    end
  end

  // R2
  mode_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(chan_op) |-> $past(cmd_done));

  // R10
  no_wr_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(teds_we && rep_busy));
endmodule

// File: tb/sim_tcmd_decoder.sv
module sim_tcmd_decoder;
  localparam int DEPTH = 16;
  localparam int RN    = 4;
  localparam int WB    = 4;
  localparam int TMO   = 40;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, rx_valid = 1'b0, tx_ready = 1'b1;
  logic [7:0] rx_data = 8'h00;
  logic tx_valid, chan_op, teds_we;
  logic [7:0] tx_data, teds_wdata, teds_rdata;
  logic [AW-1:0] teds_addr;

  tcmd_decoder #(.CHAN_ID(1), .TEDS_ID(3), .DEPTH(DEPTH), .READ_N(RN),
                 .WBUF_N(WB), .TIMEOUT(TMO)) u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .chan_op(chan_op), .teds_we(teds_we), .teds_addr(teds_addr),
    .teds_wdata(teds_wdata), .teds_rdata(teds_rdata)
  );

  // descriptor store model
  logic [7:0] mem [DEPTH];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (teds_we) mem[teds_addr] <= teds_wdata;
    teds_rdata <= mem[teds_addr];
  end

  // reply capture
  logic [7:0] rq [4096];
  int rq_n = 0;
  always @(negedge clk) begin
    if (tx_valid && tx_ready) begin
      if (rq_n < 4096) rq[rq_n] = tx_data;
      rq_n = rq_n + 1;
    end
  end

  // ready pattern
  int rdy_mode = 0;
  always @(posedge clk) begin
    logic [7:0] lf;
    #1;
    lf = 8'hA5;
    lf = 8'(($time / 8) * 37 + 11);
    case (rdy_mode)
      0: tx_ready = 1'b1;
      1: tx_ready = lf[2] ^ lf[5];
      default: tx_ready = 1'b0;
    endcase
  end

  int errors = 0, checks = 0;
  logic [7:0] smem [DEPTH];
  logic [7:0] fb [64];
  int fb_n;
  logic [7:0] ex [16];
  int ex_n;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    fb[fb_n] = b;
    fb_n++;
  endtask

  task automatic hdr(input logic [15:0] ch, input logic [7:0] cls, input logic [7:0] fn, input logic [15:0] len);
    fb_n = 0;
    push(ch[15:8]); push(ch[7:0]); push(cls); push(fn); push(len[15:8]); push(len[7:0]);
  endtask

  task automatic send_frame();
    for (int i = 0; i < fb_n; i++) begin
      @(posedge clk); #1;
      rx_valid = 1'b1; rx_data = fb[i];
      @(posedge clk); #1;
      rx_valid = 1'b0;
    end
  endtask

  task automatic exp_code(input logic [7:0] c);
    ex[0] = (c >= 8'hC7) ? 8'h01 : 8'h00;
    ex[1] = 8'h00; ex[2] = 8'h01; ex[3] = c; ex_n = 4;
  endtask

  task automatic exp_read(input int off);
    ex[0] = 8'h01; ex[1] = 8'h00; ex[2] = 8'(1 + RN); ex[3] = 8'hC8;
    for (int i = 0; i < RN; i++) ex[4 + i] = smem[off + i];
    ex_n = 4 + RN;
  endtask

  task automatic do_cmd(input string tag);
    int b0;
    b0 = rq_n;
    send_frame();
    for (int w = 0; w < 3000 && rq_n < b0 + ex_n; w++) @(posedge clk);
    repeat (12) @(posedge clk);
    chk(rq_n - b0 == ex_n, {tag, " reply length"}, rq_n - b0, ex_n);
    for (int i = 0; i < ex_n; i++)
      chk(rq[b0 + i] == ex[i], {tag, " reply octet"}, rq[b0 + i], ex[i]);
  endtask

  task automatic rd_frame(input logic [31:0] off, input logic [7:0] tid);
    hdr(16'h0001, 8'h01, 8'h02, 16'd5);
    push(tid); push(off[31:24]); push(off[23:16]); push(off[15:8]); push(off[7:0]);
  endtask

  task automatic wr_frame(input logic [31:0] off, input logic [7:0] tid, input int n, input bit bad);
    logic [7:0] s, d;
    s = 8'h00;
    hdr(16'h0001, 8'h01, 8'h03, 16'(6 + n));
    push(tid); push(off[31:24]); push(off[23:16]); push(off[15:8]); push(off[7:0]);
    for (int i = 0; i < n; i++) begin
      d = 8'(off * 13 + i * 5 + n + 8'h40);
      s = s + d;
      push(d);
    end
    push(bad ? (~s ^ 8'h01) : ~s);
  endtask

  task automatic commit_mirror(input int off, input int n);
    for (int i = 0; i < n; i++) smem[off + i] = 8'(off * 13 + i * 5 + n + 8'h40);
  endtask

  task automatic store_match(input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] !== smem[i]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) smem[i] = 8'(i * 7 + 3);
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R2 R12 reset state
    chk(tx_valid == 1'b0, "R12 reset tx_valid", tx_valid, 0);
    chk(chan_op == 1'b0, "R2 reset chan_op", chan_op, 0);
    chk(teds_we == 1'b0, "R10 reset teds_we", teds_we, 0);

    // R1 R2 operate / idle
    hdr(16'h0001, 8'h04, 8'h01, 16'd0); exp_code(8'hC7); do_cmd("R1 operate");
    chk(chan_op == 1'b1, "R2 operate mode", chan_op, 1);
    hdr(16'h0001, 8'h04, 8'h02, 16'd0); exp_code(8'hC7); do_cmd("R1 idle");
    chk(chan_op == 1'b0, "R2 idle mode", chan_op, 0);

    // R4 R5 class/function sweep
    for (int c = 0; c < 6; c++) begin
      for (int f = 0; f < 5; f++) begin
        logic exp_mode;
        exp_mode = chan_op;
        hdr(16'h0001, 8'(c), 8'(f), 16'd0);
        if (c == 4 && f == 1) begin exp_code(8'hC7); exp_mode = 1'b1; end
        else if (c == 4 && f == 2) begin exp_code(8'hC7); exp_mode = 1'b0; end
        else if (c == 1 && (f == 2 || f == 3)) exp_code(8'hC0);
        else exp_code(8'hC2);
        do_cmd("R4 class/function sweep");
        chk(chan_op == exp_mode, "R2 mode after sweep entry", chan_op, exp_mode);
      end
    end

    // R3 channel sweep, precedence over class and length
    hdr(16'h0001, 8'h04, 8'h01, 16'd0); exp_code(8'hC7); do_cmd("R1 operate again");
    for (int k = 0; k < 4; k++) begin
      logic [15:0] ch;
      ch = (k == 0) ? 16'h0000 : (k == 1) ? 16'h0002 : (k == 2) ? 16'h0101 : 16'hFFFF;
      hdr(ch, 8'h04, 8'h02, 16'd0); exp_code(8'hC1); do_cmd("R3 bad channel");
      chk(chan_op == 1'b1, "R2 mode kept on R3 failure", chan_op, 1);
    end
    hdr(16'h0002, 8'h07, 8'h09, 16'd2); push(8'h11); push(8'h22);
    exp_code(8'hC1); do_cmd("R3 precedence over R4");

    // R5 length mismatches, payload consumed exactly
    hdr(16'h0001, 8'h01, 8'h02, 16'd4); for (int i = 0; i < 4; i++) push(8'h03);
    exp_code(8'hC0); do_cmd("R5 read length 4");
    hdr(16'h0001, 8'h01, 8'h02, 16'd6); for (int i = 0; i < 6; i++) push(8'h00);
    exp_code(8'hC0); do_cmd("R5 read length 6");
    hdr(16'h0001, 8'h04, 8'h02, 16'd1); push(8'h00);
    exp_code(8'hC0); do_cmd("R5 idle length 1");
    chk(chan_op == 1'b1, "R2 mode kept on R5 failure", chan_op, 1);
    hdr(16'h0001, 8'h01, 8'h03, 16'd6); for (int i = 0; i < 6; i++) push(8'h03);
    exp_code(8'hC0); do_cmd("R5 write length 6");
    wr_frame(32'd0, 8'h03, WB + 1, 1'b0);
    exp_code(8'hC0); do_cmd("R5 write too long");
    store_match("R10 store after R5 rejects");

    // R6 R9 R12 read offset sweep with stalling transmitter
    rdy_mode = 1;
    for (int off = 0; off <= DEPTH; off++) begin
      rd_frame(32'(off), 8'h03);
      if (off + RN <= DEPTH) exp_read(off); else exp_code(8'hC5);
      do_cmd("R6 R12 read sweep");
    end
    rdy_mode = 0;
    rd_frame(32'h0001_0000, 8'h03); exp_code(8'hC5); do_cmd("R9 offset high octets");
    rd_frame(32'd0, 8'h02); exp_code(8'hC4); do_cmd("R8 read bad id");
    rd_frame(32'd200, 8'h07); exp_code(8'hC4); do_cmd("R8 precedence over R9");

    // R7 write sweep at both ends of the store
    for (int n = 1; n <= WB; n++) begin
      for (int e = 0; e < 2; e++) begin
        int off, roff;
        off = (e == 0) ? 0 : DEPTH - n;
        wr_frame(32'(off), 8'h03, n, 1'b0); exp_code(8'hC7);
        commit_mirror(off, n);
        do_cmd("R7 write sweep");
        store_match("R7 store contents");
        roff = (off + RN <= DEPTH) ? off : DEPTH - RN;
        rd_frame(32'(roff), 8'h03); exp_read(roff); do_cmd("R6 R7 read back");
      end
    end

    // R9 R10 R8 rejected writes
    wr_frame(32'(DEPTH - 1), 8'h03, 2, 1'b0); exp_code(8'hC5); do_cmd("R9 write past end");
    wr_frame(32'd3, 8'h03, 3, 1'b1); exp_code(8'hC6); do_cmd("R10 bad check octet");
    wr_frame(32'd20, 8'h03, 2, 1'b1); exp_code(8'hC5); do_cmd("R9 precedence over R10");
    wr_frame(32'd2, 8'h05, 2, 1'b1); exp_code(8'hC4); do_cmd("R8 write bad id");
    store_match("R10 store unchanged");

    // R11 timeouts
    hdr(16'h0001, 8'h04, 8'h02, 16'd0); fb_n = 3;
    exp_code(8'hC3); do_cmd("R11 header timeout");
    rd_frame(32'd1, 8'h03); fb_n = 8;
    exp_code(8'hC3); do_cmd("R11 payload timeout");
    chk(chan_op == 1'b1, "R2 mode kept on R11", chan_op, 1);
    hdr(16'h0001, 8'h04, 8'h02, 16'd0); exp_code(8'hC7); do_cmd("R11 recovery idle");
    chk(chan_op == 1'b0, "R2 idle after R11", chan_op, 0);

    // R13 octets during a stalled reply are dropped
    begin
      int b0;
      b0 = rq_n;
      rdy_mode = 2;
      hdr(16'h0001, 8'h04, 8'h01, 16'd0); send_frame();
      hdr(16'h0001, 8'h04, 8'h02, 16'd0); send_frame();
      repeat (5) @(posedge clk);
      rdy_mode = 0;
      repeat (60) @(posedge clk);
      chk(rq_n - b0 == 4, "R13 single reply", rq_n - b0, 4);
      chk(rq[b0 + 3] == 8'hC7, "R13 reply code", rq[b0 + 3], 8'hC7);
      chk(chan_op == 1'b1, "R13 dropped idle", chan_op, 1);
    end
    hdr(16'h0001, 8'h04, 8'h02, 16'd0); exp_code(8'hC7); do_cmd("R13 next frame");
    chk(chan_op == 1'b0, "R2 final idle", chan_op, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule